// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block trims the set of output ports that a frame may reach in a nine-port switch. It takes the ingress port index, the destination vector from address lookup, a frame-class code and the per-port VLAN configuration. It returns a registered egress vector with a drop flag, one cycle after the inputs are sampled.

Each ingress port owns an 8-bit membership mask. The mask lists only the eight *other* ports, in ascending index order, with the ingress port's own position left out. For example, port 0's bit 0 names port 1, and port 8's bit 7 names port 7.

Masks are independent, so asymmetric groupings can be built. One such grouping is a hub in which eight ports see only the ninth, while the ninth sees them all. Group-addressed frames always obey the masks. Unicast frames obey them only when a global enforcement bit is set.

Top module: `vlan_egress_filter`

## Requirements
- R1: For ingress port i (0 to 8), mask bit k names port k when k < i and port k+1 when k >= i. The ingress port has no mask bit.
- R2: For frame class codes 1 (multicast), 2 (broadcast) and 3 (reserved, handled as group-addressed), the egress vector is limited to the ports named in the ingress port's mask.
- R3: For class code 0 (unicast) with `cfg_ucast_enforce` = 1, the egress vector is limited by the mask in the same way.
- R4: For class code 0 with `cfg_ucast_enforce` = 0, the mask is ignored. The egress vector equals the lookup vector with the ingress bit cleared.
- R5: The ingress port's own bit is always 0 in the egress vector.
- R6: The egress vector never holds a port that is absent from the lookup vector.
- R7: `out_drop` is 1 exactly when a result is valid and its egress vector is all zero.
- R8: Inputs sampled with `in_valid` = 1 at a rising edge produce their result on the outputs right after that edge, with `out_valid` = 1. `out_valid` mirrors `in_valid` from the previous edge.
- R9: An ingress index of 9 or above yields an empty egress vector and `out_drop` = 1.
- R10: While reset is applied, and until the first valid input, `out_valid`, `out_egress_vec` and `out_drop` are 0.
- R11: At an edge where `in_valid` = 0, `out_egress_vec` and `out_drop` keep their values, and `out_valid` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Frame descriptor present this cycle |
| in_port | input | 4 | Ingress port index, 0 to 8 |
| in_kind | input | 2 | Frame class: 0 unicast, 1 multicast, 2 broadcast, 3 reserved |
| in_dest_vec | input | 9 | Destination ports from address lookup, bit n = port n |
| cfg_masks | input | 72 | Nine 8-bit masks; the mask of port p is at bits [8p+7:8p] |
| cfg_ucast_enforce | input | 1 | 1: unicast obeys the masks |
| out_valid | output | 1 | Result valid |
| out_egress_vec | output | 9 | Filtered egress ports, bit n = port n |
| out_drop | output | 1 | Result has no egress port |

## Verification
Every result is due exactly one rising edge after its inputs are sampled. Reset release, however, takes two extra edges through the internal synchronizer, and the bench waits those out before its first vector.

The bench drives each vector on a falling edge and lets one rising edge pass. It then compares all three outputs on the next falling edge, away from the edge that updates them.

For the hold checks, the bench drives fresh inputs with `in_valid` low and compares at the same falling-edge point one cycle later. It expects the previous result to be unchanged and `out_valid` to be 0.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;

  typedef enum logic [1:0] {
    KIND_UCAST = 2'd0,
    KIND_MCAST = 2'd1,
    KIND_BCAST = 2'd2,
    KIND_RSVD  = 2'd3
  } frame_kind_e;

  function automatic logic kind_is_group(input logic [1:0] kind);
    return kind != KIND_UCAST;
  endfunction

endpackage

// File: rtl/vlan_rst_sync.sv
module vlan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vlan_port_decode.sv
module vlan_port_decode #(
  parameter int NUM_PORTS = 9,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic [PORT_W-1:0]    port_idx,
  output logic [NUM_PORTS-1:0] port_onehot,
  output logic                 port_bad
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign port_onehot[p] = (port_idx == PORT_W'(p));
  end

  assign port_bad = (int'(port_idx) >= NUM_PORTS);

endmodule

// File: rtl/vlan_mask_view.sv
// Spreads one ingress port's compressed mask over the full port range,
// leaving a hole at the owner's position.
module vlan_mask_view #(
  parameter int NUM_PORTS = 9,
  parameter int OWNER     = 0,
  localparam int MASK_W   = NUM_PORTS - 1
) (
  input  logic [MASK_W-1:0]    mask,
  output logic [NUM_PORTS-1:0] view
);

  for (genvar j = 0; j < NUM_PORTS; j++) begin : g_bit
    if (j < OWNER) begin : g_below
      assign view[j] = mask[j];
    end else if (j == OWNER) begin : g_self
      assign view[j] = 1'b0;
    end else begin : g_above
      assign view[j] = mask[j-1];
    end
  end

endmodule

// File: rtl/vlan_filter_core.sv
module vlan_filter_core
  import vlan_filt_pkg::*;
#(
  parameter int NUM_PORTS = 9
) (
  input  logic [1:0]           kind,
  input  logic                 ucast_enforce,
  input  logic                 port_bad,
  input  logic [NUM_PORTS-1:0] port_onehot,
  input  logic [NUM_PORTS-1:0] sel_view,
  input  logic [NUM_PORTS-1:0] dest_vec,
  output logic [NUM_PORTS-1:0] egress_vec,
  output logic                 egress_empty
);

  logic                 restrict_en;
  logic [NUM_PORTS-1:0] allowed;

  always_comb begin
    restrict_en = kind_is_group(kind) || ucast_enforce;
    allowed     = restrict_en ? sel_view : {NUM_PORTS{1'b1}};
    if (port_bad) egress_vec = '0;
    else          egress_vec = dest_vec & allowed & ~port_onehot;
    egress_empty = (egress_vec == '0);
  end

endmodule

// File: rtl/vlan_egress_filter.sv
module vlan_egress_filter
  import vlan_filt_pkg::*;
#(
  parameter int  NUM_PORTS = 9,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int MASK_W    = NUM_PORTS - 1,
  localparam int CFG_W     = NUM_PORTS * MASK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [1:0]           in_kind,
  input  logic [NUM_PORTS-1:0] in_dest_vec,
  input  logic [CFG_W-1:0]     cfg_masks,
  input  logic                 cfg_ucast_enforce,
  output logic                 out_valid,
  output logic [NUM_PORTS-1:0] out_egress_vec,
  output logic                 out_drop
);

  logic                 rst_sync_n;
  logic [NUM_PORTS-1:0] port_onehot;
  logic                 port_bad;
  logic [NUM_PORTS-1:0] views [NUM_PORTS];
  logic [NUM_PORTS-1:0] sel_view;
  logic [NUM_PORTS-1:0] egress_d;
  logic                 empty_d;

  logic                 valid_q, valid_d;
  logic [NUM_PORTS-1:0] egress_q, egress_nx;
  logic                 drop_q, drop_nx;

  vlan_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  vlan_port_decode #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dec (
    .port_idx(in_port), .port_onehot(port_onehot), .port_bad(port_bad)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_view
    vlan_mask_view #(.NUM_PORTS(NUM_PORTS), .OWNER(p)) u_view (
      .mask(cfg_masks[p*MASK_W +: MASK_W]),
      .view(views[p])
    );
  end

  // AND-OR select of the ingress port's expanded mask
  always_comb begin
    sel_view = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      sel_view |= views[p] & {NUM_PORTS{port_onehot[p]}};
    end
  end

  vlan_filter_core #(.NUM_PORTS(NUM_PORTS)) u_core (
    .kind(in_kind),
    .ucast_enforce(cfg_ucast_enforce),
    .port_bad(port_bad),
    .port_onehot(port_onehot),
    .sel_view(sel_view),
    .dest_vec(in_dest_vec),
    .egress_vec(egress_d),
    .egress_empty(empty_d)
  );

  // next-state: data loads only under its clock enable
  always_comb begin
    valid_d   = in_valid;
    egress_nx = egress_q;
    drop_nx   = drop_q;
    if (in_valid) begin
      egress_nx = egress_d;
      drop_nx   = empty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      egress_q <= '0;
      drop_q   <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      egress_q <= egress_nx;
      drop_q   <= drop_nx;
    end
  end

  assign out_valid      = valid_q;
  assign out_egress_vec = egress_q;
  assign out_drop       = drop_q;

  a_r5_ingress_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(rst_sync_n)) |-> ((out_egress_vec & $past(port_onehot)) == '0));

  a_r6_within_lookup: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(rst_sync_n)) |-> ((out_egress_vec & ~$past(in_dest_vec)) == '0));

  a_r2_group_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && $past(rst_sync_n) && $past(in_kind) != KIND_UCAST)
      |-> ((out_egress_vec & ~$past(sel_view)) == '0));

  a_r7_drop_when_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_drop == (out_egress_vec == '0)));

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (out_valid == $past(in_valid)));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(in_valid)) |-> ($stable(out_egress_vec) && $stable(out_drop)));

  a_r9_port_decode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    port_bad ? (port_onehot == '0) : $onehot(port_onehot));

endmodule

// File: tb/vlan_egress_filter_test.sv
`timescale 1ns/1ps
module vlan_egress_filter_test;

  localparam int NP = 9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_port;
  logic [1:0]  in_kind;
  logic [8:0]  in_dest_vec;
  logic [71:0] cfg_masks;
  logic        cfg_ucast_enforce;
  logic        out_valid;
  logic [8:0]  out_egress_vec;
  logic        out_drop;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  vlan_egress_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .in_kind(in_kind), .in_dest_vec(in_dest_vec), .cfg_masks(cfg_masks),
    .cfg_ucast_enforce(cfg_ucast_enforce), .out_valid(out_valid),
    .out_egress_vec(out_egress_vec), .out_drop(out_drop)
  );

  always #2.5 clk = ~clk;

  function automatic logic [8:0] model(input int port, input int kind,
                                       input logic [8:0] dest, input logic enf,
                                       input logic [71:0] cfg);
    logic [8:0] allow;
    if (port >= NP) return 9'h0;
    allow = 9'h1FF;
    if (kind != 0 || enf) begin
      allow = 9'h0;
      for (int k = 0; k < 8; k++)
        if (cfg[port*8 + k]) allow[(k >= port) ? k + 1 : k] = 1'b1;
    end
    return dest & allow & ~(9'h1 << port);
  endfunction

  task automatic check(input string tag, input logic v, input logic [8:0] e,
                       input logic d, input logic ev, input logic [8:0] ee,
                       input logic ed);
    n_vec++;
    if (v !== ev || e !== ee || d !== ed) begin
      n_fail++;
      $display("FAIL %s: valid/vec/drop got %b/%h/%b expected %b/%h/%b",
               tag, v, e, d, ev, ee, ed);
    end
  endtask

  task automatic apply(input string tag, input int port, input int kind,
                       input logic [8:0] dest, input logic enf);
    logic [8:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_port = 4'(port); in_kind = 2'(kind);
    in_dest_vec = dest; cfg_ucast_enforce = enf;
    exp = model(port, kind, dest, enf, cfg_masks);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid, out_egress_vec, out_drop, 1'b1, exp, exp == 9'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [8:0] pats [13];
    logic [8:0] prev_e;
    logic       prev_d;
    logic [31:0] lf;
    rst_n = 1'b0; in_valid = 1'b0; in_port = '0; in_kind = '0;
    in_dest_vec = '0; cfg_masks = '0; cfg_ucast_enforce = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs cleared under reset
    check("R10", out_valid, out_egress_vec, out_drop, 1'b0, 9'h0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", out_valid, out_egress_vec, out_drop, 1'b0, 9'h0, 1'b0);

    // R1: single mask bit selects exactly one port
    for (int i = 0; i < NP; i++) begin
      for (int k = 0; k < 8; k++) begin
        cfg_masks = '0;
        cfg_masks[i*8 + k] = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_port = 4'(i); in_kind = 2'd2;
        in_dest_vec = 9'h1FF; cfg_ucast_enforce = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", out_valid, out_egress_vec, out_drop, 1'b1,
              9'h1 << (k + ((k >= i) ? 1 : 0)), 1'b0);
      end
    end

    // R5: everything allowed, only the ingress bit is removed
    cfg_masks = {72{1'b1}};
    for (int i = 0; i < NP; i++) apply("R5", i, 0, 9'h1FF, 1'b0);

    // R8/R11: idle cycle keeps data, drops valid
    apply("R8", 3, 1, 9'h0F0, 1'b1);
    prev_e = out_egress_vec; prev_d = out_drop;
    @(negedge clk);
    in_valid = 1'b0; in_port = 4'd0; in_dest_vec = 9'h001; in_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    check("R11", out_valid, out_egress_vec, out_drop, 1'b0, prev_e, prev_d);

    pats[0] = 9'h000; pats[1] = 9'h1FF; pats[2] = 9'h155; pats[3] = 9'h0AA;
    for (int b = 0; b < NP; b++) pats[4 + b] = 9'h1 << b;

    lf = 32'hACE1_1234;
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < NP; p++) begin
        case (c)
          0: cfg_masks[p*8 +: 8] = (p == 8) ? 8'hFF : 8'h80; // hub on port 8
          1: cfg_masks[p*8 +: 8] = 8'hFF;
          2: begin
               lf = lf * 32'd1664525 + 32'd1013904223;
               cfg_masks[p*8 +: 8] = lf[23:16];
             end
          default: cfg_masks[p*8 +: 8] = 8'h01 << (p % 8);
        endcase
      end
      for (int port = 0; port < 16; port++)
        for (int kind = 0; kind < 4; kind++)
          for (int enf = 0; enf < 2; enf++)
            for (int q = 0; q < 13; q++) begin
              string tag;
              if (port >= NP)    tag = "R9";
              else if (kind != 0) tag = "R2";
              else if (enf != 0)  tag = "R3";
              else                tag = "R4";
              if (q == 0) tag = {tag, "/R7"};
              if (q == 1) tag = {tag, "/R6"};
              apply(tag, port, kind, pats[q], enf[0]);
            end
      // R11 hold after a sweep of this configuration
      prev_e = out_egress_vec; prev_d = out_drop;
      @(negedge clk);
      in_valid = 1'b0; in_port = 4'd1; in_dest_vec = ~in_dest_vec;
      @(posedge clk);
      @(negedge clk);
      check("R11", out_valid, out_egress_vec, out_drop, 1'b0, prev_e, prev_d);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule